// File: doc/BRIEF.md
# RV64 Integer Multiply Unit

This block computes the multiply family of a 64-bit integer pipeline on two 64-bit source operands. A start pulse hands it the two operands, a 2-bit operation code taken from the low bits of funct3, and a word-mode flag. It runs an iterative shift-add datapath that always forms the full 128-bit product. When the product is ready, it raises a done strobe for a single cycle, with the 64-bit result on `result_o`.

One datapath serves all four full-width operations. It returns either the low half of the product or the high half. For the high half it supports three signedness combinations: signed×signed, signed×unsigned and unsigned×unsigned. The datapath multiplies unsigned magnitudes and fixes the sign of the 128-bit product at the end. Each operand is widened by one guard bit before its magnitude is taken, so an unsigned operand whose top bit is set is never read as negative.

In word mode only the low 32 bits of each operand are multiplied. The 32-bit result is sign-extended to 64 bits, and the unit finishes in half the iterations of a full-width operation. Decode, register access, writeback and exceptions belong to the surrounding pipeline. Choosing the multiply group from funct7 bit 0 also belongs to the pipeline's decoder, not to this block.

Top module: `mul64_unit`

## Requirements
- R1: With word_i=0 and op_i=0, result_o on the done cycle equals bits [63:0] of rs1_i×rs2_i.
- R2: With word_i=0 and op_i=1, both operands are signed 64-bit values and result_o equals bits [127:64] of their 128-bit product.
- R3: With word_i=0 and op_i=2, rs1_i is signed, rs2_i is unsigned, and result_o equals bits [127:64] of the product.
- R4: With word_i=0 and op_i=3, both operands are unsigned and result_o equals bits [127:64] of the product.
- R5: With word_i=1, result_o equals the low 32 bits of rs1_i[31:0]×rs2_i[31:0], sign-extended from bit 31 to 64 bits; op_i has no effect in word mode.
- R6: done_o is high for exactly one cycle. That cycle comes 64/DIGIT_W clock edges after the edge that accepted start_i in full mode, and 32/DIGIT_W edges after it in word mode (16 and 8 with the default DIGIT_W=4).
- R7: A start_i that is high while busy_o is high is ignored: no extra done_o occurs, and the running operation finishes with its own result at its own time.
- R8: While rst_ni is low, busy_o and done_o are low.
- R9: busy_o is high from the edge that accepts start_i until the edge that raises done_o, and is low while done_o is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request; accepted when busy_o is low |
| op_i | input | 2 | 0 low product, 1 high signed×signed, 2 high signed×unsigned, 3 high unsigned×unsigned |
| word_i | input | 1 | Word mode: 32-bit multiply, sign-extended result |
| rs1_i | input | 64 | First operand |
| rs2_i | input | 64 | Second operand |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle strobe; result_o is valid |
| result_o | output | 64 | Selected product half or word result |

## Verification
The bench goes after the operands where sign handling breaks: zero, one, all-ones, the minimum signed value and the maximum positive value, in every pairing and under every operation.

- A unit without the guard bit would read all-ones as -1 in the unsigned high product, so it would return a high half of zero or a sign-flipped value.
- A sign fix that negates only 64 bits would corrupt the signed high product whenever a low-half borrow has to ripple upward.
- Mixing minimum-signed operands exposes a magnitude path that overflows.
- Word-mode cases with bit 31 set catch a missing sign extension, and so do word-mode cases sent with a nonzero op_i.
- Extra start pulses sent while busy catch a unit that restarts or emits a second done: the scoreboard sees a done it never expected, or a wrong latency.

// File: rtl/mul64_pkg.sv
package mul64_pkg;
  typedef enum logic [1:0] {
    OP_LO  = 2'd0,
    OP_HSS = 2'd1,
    OP_HSU = 2'd2,
    OP_HUU = 2'd3
  } mul_op_e;

  typedef struct packed {
    logic neg;
    logic word;
    logic hi;
  } mul_ctl_t;
endpackage

// File: rtl/mul64_operand_prep.sv
module mul64_operand_prep #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] val_i,
  input  logic            is_signed_i,
  input  logic            word_i,
  output logic [XLEN-1:0] mag_o,
  output logic            neg_o
);
  localparam int HALF = XLEN / 2;

  logic [XLEN:0] ext;
  logic [XLEN:0] ext_neg;

  // guard bit keeps unsigned operands with msb set non-negative
  assign ext     = {is_signed_i & val_i[XLEN-1], val_i};
  assign ext_neg = ~ext + {{XLEN{1'b0}}, 1'b1};
  assign neg_o   = ext[XLEN];

  always_comb begin
    if (word_i)    mag_o = {{(XLEN-HALF){1'b0}}, val_i[HALF-1:0]};
    else if (neg_o) mag_o = ext_neg[XLEN-1:0];
    else           mag_o = val_i;
  end
endmodule

// File: rtl/mul64_shift_add_core.sv
module mul64_shift_add_core #(
  parameter int XLEN    = 64,
  parameter int DIGIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              word_i,
  input  logic [XLEN-1:0]   mcand_i,
  input  logic [XLEN-1:0]   mplier_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [2*XLEN-1:0] prod_o
);
  localparam int STEPS_FULL = XLEN / DIGIT_W;
  localparam int STEPS_WORD = XLEN / 2 / DIGIT_W;
  localparam int CNT_W      = $clog2(STEPS_FULL + 1);
  localparam int SUM_W      = XLEN + DIGIT_W;
  localparam logic [CNT_W-1:0] LAST_FULL = CNT_W'(STEPS_FULL - 1);
  localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(STEPS_WORD - 1);

  logic [2*XLEN-1:0] prod_q;
  logic [XLEN-1:0]   mcand_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q, done_q, word_q;
  logic [SUM_W-1:0]  pp, hi_sum;
  logic              last_step;

  assign pp        = {{DIGIT_W{1'b0}}, mcand_q} * {{XLEN{1'b0}}, prod_q[DIGIT_W-1:0]};
  assign hi_sum    = {{DIGIT_W{1'b0}}, prod_q[2*XLEN-1:XLEN]} + pp;
  assign last_step = (cnt_q == (word_q ? LAST_WORD : LAST_FULL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q  <= '0;
      mcand_q <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      word_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_i && !busy_q) begin
        prod_q  <= {{XLEN{1'b0}}, mplier_i};
        mcand_q <= mcand_i;
        cnt_q   <= '0;
        busy_q  <= 1'b1;
        word_q  <= word_i;
      end else if (busy_q) begin
        prod_q <= {hi_sum, prod_q[XLEN-1:DIGIT_W]};
        cnt_q  <= cnt_q + CNT_W'(1);
        if (last_step) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign prod_o = prod_q;
endmodule

// File: rtl/mul64_result_select.sv
module mul64_result_select #(
  parameter int XLEN = 64
) (
  input  logic [2*XLEN-1:0]       prod_i,
  input  mul64_pkg::mul_ctl_t     ctl_i,
  output logic [XLEN-1:0]         result_o
);
  localparam int HALF = XLEN / 2;

  logic [2*XLEN-1:0] fixed;
  logic [HALF-1:0]   word_lo;

  assign fixed   = ctl_i.neg ? (~prod_i + {{(2*XLEN-1){1'b0}}, 1'b1}) : prod_i;
  // word-mode product ends HALF bits up after the shortened run
  assign word_lo = prod_i[XLEN-1:HALF];

  always_comb begin
    if (ctl_i.word)    result_o = {{(XLEN-HALF){word_lo[HALF-1]}}, word_lo};
    else if (ctl_i.hi) result_o = fixed[2*XLEN-1:XLEN];
    else               result_o = fixed[XLEN-1:0];
  end
endmodule

// File: rtl/mul64_unit.sv
module mul64_unit
  import mul64_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int DIGIT_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [1:0]      op_i,
  input  logic            word_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [XLEN-1:0] result_o
);
  localparam int NOPS = 2;

  logic [NOPS-1:0][XLEN-1:0] opnd, mag;
  logic [NOPS-1:0]           sgn, neg;
  logic                      accept;
  logic [2*XLEN-1:0]         prod;
  mul_ctl_t                  ctl_q;
  mul_op_e                   op;

  assign op      = mul_op_e'(op_i);
  assign opnd[0] = rs1_i;
  assign opnd[1] = rs2_i;
  assign sgn[0]  = !word_i && (op == OP_HSS || op == OP_HSU);
  assign sgn[1]  = !word_i && (op == OP_HSS);
  assign accept  = start_i && !busy_o;

  for (genvar g = 0; g < NOPS; g++) begin : g_prep
    mul64_operand_prep #(.XLEN(XLEN)) u_prep (
      .val_i       (opnd[g]),
      .is_signed_i (sgn[g]),
      .word_i      (word_i),
      .mag_o       (mag[g]),
      .neg_o       (neg[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (accept) begin
      ctl_q.neg  <= neg[0] ^ neg[1];
      ctl_q.word <= word_i;
      ctl_q.hi   <= (op != OP_LO);
    end
  end

  mul64_shift_add_core #(.XLEN(XLEN), .DIGIT_W(DIGIT_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (start_i),
    .word_i   (word_i),
    .mcand_i  (mag[0]),
    .mplier_i (mag[1]),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .prod_o   (prod)
  );

  mul64_result_select #(.XLEN(XLEN)) u_sel (
    .prod_i   (prod),
    .ctl_i    (ctl_q),
    .result_o (result_o)
  );
endmodule

// File: rtl/mul64_unit_chk.sv
module mul64_unit_chk #(
  parameter int XLEN    = 64,
  parameter int DIGIT_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            word_i,
  input logic            busy_o,
  input logic            done_o,
  input logic [XLEN-1:0] result_o
);
  localparam int LAT_F = XLEN / DIGIT_W;
  localparam int LAT_W = XLEN / 2 / DIGIT_W;

  logic       word_q;
  logic [7:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= 1'b0;
      cyc_q  <= '0;
    end else if (start_i && !busy_o) begin
      word_q <= word_i;
      cyc_q  <= '0;
    end else if (busy_o) begin
      cyc_q <= cyc_q + 8'd1;
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_idle_R8: assert (!busy_o && !done_o)
        else $error("busy/done high in reset");
    end
  end

  assert_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cyc_q == (word_q ? 8'(LAT_W) : 8'(LAT_F)))
    else $error("done latency wrong");

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o)
    else $error("done wider than one cycle");

  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o)
    else $error("busy high with done");

  assert_accept_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !done_o))
    else $error("accept did not raise busy");

  assert_restart_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o && cyc_q < 8'(LAT_W - 1)) |=> (busy_o && !done_o))
    else $error("start while busy disturbed run");

  assert_word_sext_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && word_q) |-> result_o[XLEN-1:XLEN/2] == {(XLEN/2){result_o[XLEN/2-1]}})
    else $error("word result not sign-extended");
endmodule

bind mul64_unit mul64_unit_chk #(.XLEN(XLEN), .DIGIT_W(DIGIT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .word_i   (word_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .result_o (result_o)
);

// File: tb/mul64_unit_test.sv
`timescale 1ns/1ps
module mul64_unit_test;
  localparam int XLEN     = 64;
  localparam int DIGIT_W  = 4;
  localparam int LAT_FULL = XLEN / DIGIT_W;
  localparam int LAT_WORD = XLEN / 2 / DIGIT_W;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = 2'd0;
  logic        word_i = 1'b0;
  logic [63:0] rs1_i = '0, rs2_i = '0;
  logic        busy_o, done_o;
  logic [63:0] result_o;

  always #2 clk_i = ~clk_i;

  mul64_unit #(.XLEN(XLEN), .DIGIT_W(DIGIT_W)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i), .word_i(word_i),
    .rs1_i(rs1_i), .rs2_i(rs2_i), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  typedef struct {
    logic [63:0] exp;
    int          t0;
    int          lat;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0, fails = 0, cyc = 0, issued = 0, dones = 0;
  bit prev_done = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_mul(input logic [63:0] a, input logic [63:0] b,
                                          input logic [1:0] op, input logic w);
    logic [127:0] ea, eb, p;
    logic [63:0]  pw;
    if (w) begin
      pw = {32'b0, a[31:0]} * {32'b0, b[31:0]};
      return {{32{pw[31]}}, pw[31:0]};
    end
    ea = (op == 2'd1 || op == 2'd2) ? {{64{a[63]}}, a} : {64'b0, a};
    eb = (op == 2'd1) ? {{64{b[63]}}, b} : {64'b0, b};
    p  = ea * eb;
    return (op == 2'd0) ? p[63:0] : p[127:64];
  endfunction

  function automatic string tag_of(input logic [1:0] op, input logic w);
    if (w) return "R5";
    case (op)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic issue(input logic [63:0] a, input logic [63:0] b, input logic [1:0] op,
                       input logic w, input int pokes);
    item_t it;
    @(negedge clk_i);
    while (busy_o || q.size() != 0) @(negedge clk_i);
    rs1_i = a; rs2_i = b; op_i = op; word_i = w; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    it.exp = ref_mul(a, b, op, w);
    it.t0  = cyc;
    it.lat = w ? LAT_WORD : LAT_FULL;
    it.tag = tag_of(op, w);
    q.push_back(it);
    issued++;
    check(busy_o === 1'b1, "R9 busy after accept", {63'b0, busy_o}, 64'd1);
    // R7: start pulses with other operands while busy
    for (int i = 0; i < pokes; i++) begin
      rs1_i = ~a; rs2_i = b ^ 64'h5555; op_i = ~op; word_i = ~w; start_i = 1'b1;
      @(negedge clk_i);
    end
    start_i = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni === 1'b1) begin
      if (prev_done) check(done_o === 1'b0, "R6 done one cycle", {63'b0, done_o}, 64'd0);
      if (done_o === 1'b1) begin
        item_t it;
        dones++;
        if (q.size() == 0) begin
          check(1'b0, "R7 unexpected done", result_o, 64'd0);
        end else begin
          it = q.pop_front();
          check(result_o === it.exp, it.tag, result_o, it.exp);
          check(cyc - it.t0 == it.lat, "R6 latency", 64'(cyc - it.t0), 64'(it.lat));
          check(busy_o === 1'b0, "R9 busy low on done", {63'b0, busy_o}, 64'd0);
        end
      end
      prev_done = (done_o === 1'b1);
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  logic [63:0] bnd [5];

  initial begin
    bnd[0] = 64'd0;
    bnd[1] = 64'd1;
    bnd[2] = '1;
    bnd[3] = 64'h8000_0000_0000_0000;
    bnd[4] = 64'h7fff_ffff_ffff_ffff;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check(busy_o === 1'b0, "R8 busy in reset", {63'b0, busy_o}, 64'd0);
    check(done_o === 1'b0, "R8 done in reset", {63'b0, done_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // boundary operands on every operation (R1..R4) and word mode (R5)
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++) begin
        for (int op = 0; op < 4; op++) issue(bnd[i], bnd[j], 2'(op), 1'b0, 0);
        issue(bnd[i], bnd[j], 2'd0, 1'b1, 0);
      end

    // word mode with bit 31 set and nonzero op (R5: op has no effect)
    issue(64'h1234_5678_8000_0001, 64'hffff_0000_0000_0003, 2'd3, 1'b1, 0);
    issue(64'h0000_0000_ffff_ffff, 64'h0000_0000_0000_0002, 2'd1, 1'b1, 0);
    issue(64'hdead_beef_7fff_ffff, 64'h0000_0000_0000_0002, 2'd2, 1'b1, 0);

    // R7: start pulses while busy
    issue(64'h0123_4567_89ab_cdef, 64'hfedc_ba98_7654_3210, 2'd1, 1'b0, 5);
    issue(64'h0000_0000_0000_0007, 64'h0000_0000_0000_0009, 2'd0, 1'b1, 3);

    // random operands
    for (int k = 0; k < 200; k++)
      issue({$urandom, $urandom}, {$urandom, $urandom}, 2'($urandom), 1'($urandom % 4 == 0), 0);

    @(negedge clk_i);
    while (q.size() != 0) @(negedge clk_i);
    repeat (3 * LAT_FULL) @(negedge clk_i);
    check(dones == issued, "R7 done count", 64'(dones), 64'(issued));
    check(busy_o === 1'b0, "R9 idle at end", {63'b0, busy_o}, 64'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule